// File: doc/BRIEF.md
# Push-Button Square Tone Source with Stepped Volume

This block turns three held note buttons into a stream of signed audio samples for a square-wave tone. It also keeps a volume setting with sixteen levels, which two pulse inputs move up and down. A tone is present only while a note button is held. The tone's pitch comes from a half-period count in system clocks, one count per note. The count is derived at elaboration from the system clock rate and the nominal note frequency. The three notes are about 262 Hz, 294 Hz and 330 Hz.

The sample's amplitude is the volume level times a fixed step. The sample is positive for the first half-period and negative for the second. The same sample goes to both the left and the right channel, ready for a stereo serializer. The level is also brought out for a display. Button inputs arrive already debounced. The volume inputs arrive as single-cycle pulses.

Top module: `tone_button_gen`

## Requirements
- R1: A synchronous reset sets the volume level to 8 and both sample outputs to 0. Both take these values at the first clock edge with reset high.
- R2: A volume-up pulse without a volume-down pulse raises the level by one at the next edge. At 15 the level stays at 15.
- R3: A volume-down pulse without a volume-up pulse lowers the level by one at the next edge. At 0 the level stays at 0.
- R4: When volume-up and volume-down pulse in the same cycle, the level does not change.
- R5: Note priority is fixed, with bit 0 (Do) above bit 1 (Re) and bit 1 above bit 2 (Mi). The chosen note's square wave spends exactly H clocks in each half. H is CLK_HZ / (2 × note frequency), rounded down.
- R6: When no note button is held, the sample output is 0 two clock edges after the buttons are sampled.
- R7: A press from idle, or a change of the winning note, restarts the wave at its positive half. The first nonzero sample appears two edges after the buttons are sampled.
- R8: The sample magnitude is level × AMP_STEP. It is positive in the first half and negative in the second. Level 0 gives a sample of 0 even while a note is held. A level change reaches the sample one edge after the level output changes.
- R9: The left and right sample outputs are equal in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| note_btn | input | 3 | Held note buttons: bit 0 Do, bit 1 Re, bit 2 Mi |
| vol_up | input | 1 | Single-cycle volume-up pulse |
| vol_down | input | 1 | Single-cycle volume-down pulse |
| sample_l | output | 16 | Left channel signed sample |
| sample_r | output | 16 | Right channel signed sample |
| level | output | 4 | Current volume level, 0 to 15 |

## Verification
A volume step and a tone edge can land in the same cycle. Examples are a level change on the edge where a half-period flips, or while a new note is restarting. The other case is an up and a down pulse arriving together. The stimulus table issues volume pulses at the first cycle of each note change, including a change to a different winning note. A bench cycle model then judges every sample's sign and magnitude against the level that held one edge earlier. Simultaneous up and down pulses are given at a mid level and at the zero bound, and the level must not move in either case.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int NUM_NOTES = 3;
  localparam int SAMPLE_W  = 16;
  localparam int LEVEL_W   = 4;
  localparam int NOTE_W    = $clog2(NUM_NOTES);

  typedef logic [NOTE_W-1:0]          note_idx_t;
  typedef logic signed [SAMPLE_W-1:0] sample_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction
endpackage

// File: rtl/tone_vol_ctrl.sv
module tone_vol_ctrl #(
  parameter int LEVEL_W     = 4,
  parameter int RESET_LEVEL = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               up_pulse,
  input  logic               down_pulse,
  output logic [LEVEL_W-1:0] level
);
  localparam logic [LEVEL_W-1:0] LVL_TOP = '1;
  localparam logic [LEVEL_W-1:0] LVL_BOT = '0;
  localparam logic [LEVEL_W-1:0] LVL_RST = LEVEL_W'(RESET_LEVEL);

  logic go_up, go_down;

  always_comb begin
    go_up   = up_pulse && !down_pulse && (level != LVL_TOP);
    go_down = down_pulse && !up_pulse && (level != LVL_BOT);
  end

  always_ff @(posedge clk) begin
    if (rst)          level <= LVL_RST;
    else if (go_up)   level <= level + 1'b1;
    else if (go_down) level <= level - 1'b1;
  end

  // R2: one step up per lone up pulse
  a_r2_step_up: assert property (@(posedge clk) disable iff (rst)
    (up_pulse && !down_pulse && level != LVL_TOP) |=> (level == $past(level) + 1'b1));
  // R2: saturation at the top
  a_r2_hold_top: assert property (@(posedge clk) disable iff (rst)
    (up_pulse && !down_pulse && level == LVL_TOP) |=> (level == LVL_TOP));
  // R3: one step down per lone down pulse
  a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
    (down_pulse && !up_pulse && level != LVL_BOT) |=> (level == $past(level) - 1'b1));
  // R3: saturation at the bottom
  a_r3_hold_bot: assert property (@(posedge clk) disable iff (rst)
    (down_pulse && !up_pulse && level == LVL_BOT) |=> (level == LVL_BOT));
  // R4: both pulses together leave the level alone
  a_r4_both_hold: assert property (@(posedge clk) disable iff (rst)
    (up_pulse && down_pulse) |=> $stable(level));
endmodule

// File: rtl/tone_note_pick.sv
module tone_note_pick
  import tone_pkg::*;
#(
  parameter int N = NUM_NOTES
) (
  input  logic [N-1:0] held,
  output note_idx_t    pick,
  output logic         any_held
);
  always_comb begin
    pick     = '0;
    any_held = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (held[i]) begin
        pick     = NOTE_W'(i);
        any_held = 1'b1;
      end
    end
  end

  always_comb begin
    // R5: the chosen note is always one that is held
    if (any_held) a_r5_pick_held: assert (held[pick]);
  end
endmodule

// File: rtl/tone_square_osc.sv
module tone_square_osc
  import tone_pkg::*;
#(
  parameter int HALF_0 = 76335,
  parameter int HALF_1 = 68027,
  parameter int HALF_2 = 60606
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      want,
  input  note_idx_t pick,
  output logic      running,
  output logic      neg_half
);
  localparam int HALF_MAX = max3(HALF_0, HALF_1, HALF_2);
  localparam int CNT_W    = $clog2(HALF_MAX + 1);
  localparam int HALF_TAB [NUM_NOTES] = '{HALF_0, HALF_1, HALF_2};

  logic [CNT_W-1:0]     cnt;
  note_idx_t            pick_q;
  logic [NUM_NOTES-1:0] at_end;
  logic                 restart;

  for (genvar g = 0; g < NUM_NOTES; g++) begin : g_end
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_TAB[g] - 1);
    assign at_end[g] = (cnt == LAST);
  end

  assign restart = !running || (pick != pick_q);

  always_ff @(posedge clk) begin
    if (rst || !want) begin
      cnt      <= '0;
      neg_half <= 1'b0;
      running  <= 1'b0;
      pick_q   <= '0;
    end else if (restart) begin
      cnt      <= '0;
      neg_half <= 1'b0;
      running  <= 1'b1;
      pick_q   <= pick;
    end else if (at_end[pick_q]) begin
      cnt      <= '0;
      neg_half <= !neg_half;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6: release stops the oscillator
  a_r6_idle: assert property (@(posedge clk) disable iff (rst)
    !want |=> (!running && !neg_half));
  // R7: a fresh or changed note starts at phase zero
  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    (want && (!running || pick != pick_q)) |=> (running && !neg_half && cnt == '0));
  // R5: counter never passes the half period of the held note
  always_comb begin
    if (!rst && running)
      a_r5_cnt_bound: assert (int'(cnt) < HALF_TAB[pick_q]);
  end
endmodule

// File: rtl/tone_button_gen.sv
module tone_button_gen
  import tone_pkg::*;
#(
  parameter int CLK_HZ      = 40_000_000,
  parameter int NOTE_HZ_0   = 262,
  parameter int NOTE_HZ_1   = 294,
  parameter int NOTE_HZ_2   = 330,
  parameter int AMP_STEP    = 2048,
  parameter int RESET_LEVEL = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_NOTES-1:0] note_btn,
  input  logic                vol_up,
  input  logic                vol_down,
  output logic [SAMPLE_W-1:0] sample_l,
  output logic [SAMPLE_W-1:0] sample_r,
  output logic [LEVEL_W-1:0]  level
);
  localparam int HALF_0 = CLK_HZ / (2 * NOTE_HZ_0);
  localparam int HALF_1 = CLK_HZ / (2 * NOTE_HZ_1);
  localparam int HALF_2 = CLK_HZ / (2 * NOTE_HZ_2);

  note_idx_t pick;
  logic      any_held;
  logic      running;
  logic      neg_half;
  sample_t   amp;
  sample_t   next_sample;

  tone_note_pick #(.N(NUM_NOTES)) u_pick (
    .held     (note_btn),
    .pick     (pick),
    .any_held (any_held)
  );

  tone_square_osc #(
    .HALF_0 (HALF_0),
    .HALF_1 (HALF_1),
    .HALF_2 (HALF_2)
  ) u_osc (
    .clk      (clk),
    .rst      (rst),
    .want     (any_held),
    .pick     (pick),
    .running  (running),
    .neg_half (neg_half)
  );

  tone_vol_ctrl #(
    .LEVEL_W     (LEVEL_W),
    .RESET_LEVEL (RESET_LEVEL)
  ) u_vol (
    .clk        (clk),
    .rst        (rst),
    .up_pulse   (vol_up),
    .down_pulse (vol_down),
    .level      (level)
  );

  always_comb begin
    amp = sample_t'(int'(level) * AMP_STEP);
    if (!running)     next_sample = '0;
    else if (neg_half) next_sample = -amp;
    else               next_sample = amp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_l <= '0;
      sample_r <= '0;
    end else begin
      sample_l <= next_sample;
      sample_r <= next_sample;
    end
  end

  // R6: idle oscillator gives silence on the next sample
  a_r6_silent: assert property (@(posedge clk) disable iff (rst)
    !running |=> (sample_l == '0));
  // R8: level zero is silent
  a_r8_zero_level: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |=> (sample_l == '0));
  // R8: first half is positive
  a_r8_pos_half: assert property (@(posedge clk) disable iff (rst)
    (running && !neg_half && level != '0) |=> ($signed(sample_l) > 0));
  // R8: second half is negative
  a_r8_neg_half: assert property (@(posedge clk) disable iff (rst)
    (running && neg_half && level != '0) |=> ($signed(sample_l) < 0));
endmodule

// File: tb/tb_tone_button_gen.sv
module tb_tone_button_gen;
  localparam int CLK_HZ = 48;
  localparam int F0 = 4, F1 = 3, F2 = 2;
  localparam int STEP = 2048;
  localparam int H [3] = '{CLK_HZ / (2 * F0), CLK_HZ / (2 * F1), CLK_HZ / (2 * F2)};

  typedef struct packed {
    logic [2:0] btn;
    logic       up;
    logic       dn;
    logic [7:0] len;
    logic [3:0] lvl;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{3'b001, 1'b0, 1'b0, 8'd30, 4'd8},
    '{3'b001, 1'b1, 1'b0, 8'd20, 4'd9},
    '{3'b011, 1'b0, 1'b1, 8'd10, 4'd8},
    '{3'b010, 1'b1, 1'b1, 8'd20, 4'd8},
    '{3'b110, 1'b1, 1'b0, 8'd20, 4'd9},
    '{3'b100, 1'b0, 1'b1, 8'd30, 4'd8},
    '{3'b000, 1'b0, 1'b0, 8'd6,  4'd8},
    '{3'b100, 1'b0, 1'b0, 8'd30, 4'd8}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  btn = '0;
  logic        up = 1'b0, dn = 1'b0;
  logic signed [15:0] sl, sr;
  logic [3:0]  lvl;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tone_button_gen #(
    .CLK_HZ(CLK_HZ), .NOTE_HZ_0(F0), .NOTE_HZ_1(F1), .NOTE_HZ_2(F2),
    .AMP_STEP(STEP), .RESET_LEVEL(8)
  ) dut (
    .clk(clk), .rst(rst), .note_btn(btn), .vol_up(up), .vol_down(dn),
    .sample_l(sl), .sample_r(sr), .level(lvl)
  );

  // bench model built from the requirements
  int m_s = 0, m_cnt = 0, m_lvl = 8, m_sel = 0;
  bit m_act = 0, m_neg = 0;
  always @(posedge clk) begin
    int ns, sel;
    bit want;
    if (rst) begin
      m_s = 0; m_act = 0; m_neg = 0; m_cnt = 0; m_sel = 0; m_lvl = 8;
    end else begin
      ns = !m_act ? 0 : (m_neg ? -m_lvl * STEP : m_lvl * STEP);
      want = |btn;
      sel = btn[0] ? 0 : (btn[1] ? 1 : 2);
      if (!want) begin
        m_act = 0; m_neg = 0; m_cnt = 0;
      end else if (!m_act || sel != m_sel) begin
        m_act = 1; m_neg = 0; m_cnt = 0; m_sel = sel;
      end else if (m_cnt == H[m_sel] - 1) begin
        m_cnt = 0; m_neg = !m_neg;
      end else begin
        m_cnt++;
      end
      if (up && !dn && m_lvl != 15) m_lvl++;
      else if (dn && !up && m_lvl != 0) m_lvl--;
      m_s = ns;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] b, input logic u, input logic d);
    btn = b; up = u; dn = d;
    @(posedge clk);
    @(negedge clk);
    up = 1'b0; dn = 1'b0;
    chk(int'(sl) == m_s, "R5 R7 R8 sample", int'(sl), m_s);
    chk(sl == sr, "R9 left/right", int'(sr), int'(sl));
    chk(int'(lvl) == m_lvl, "R2 R3 level", int'(lvl), m_lvl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int pos;
    repeat (3) @(negedge clk);
    chk(lvl == 4'd8, "R1 reset level", int'(lvl), 8);
    chk(sl == 0 && sr == 0, "R1 reset sample", int'(sl), 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      for (int c = 0; c < int'(VECS[v].len); c++)
        step(VECS[v].btn, c == 0 ? VECS[v].up : 1'b0, c == 0 ? VECS[v].dn : 1'b0);
      chk(lvl == VECS[v].lvl, "R2 R3 R4 table level", int'(lvl), int'(VECS[v].lvl));
    end

    // R2 saturation at 15 while Do sounds
    for (int i = 0; i < 10; i++) step(3'b001, 1'b1, 1'b0);
    chk(lvl == 4'd15, "R2 saturate top", int'(lvl), 15);
    for (int i = 0; i < 24; i++) step(3'b001, 1'b0, 1'b0);
    chk(sl == 16'sd30720 || sl == -16'sd30720, "R8 full magnitude", int'(sl), 30720);

    // R3 saturation at 0, R8 silence at level 0
    for (int i = 0; i < 20; i++) step(3'b001, 1'b0, 1'b1);
    chk(lvl == 4'd0, "R3 saturate bottom", int'(lvl), 0);
    for (int i = 0; i < 12; i++) begin
      step(3'b001, 1'b0, 1'b0);
      chk(sl == 0, "R8 level zero silent", int'(sl), 0);
    end
    step(3'b001, 1'b1, 1'b1);
    chk(lvl == 4'd0, "R4 both at bottom", int'(lvl), 0);

    // R7 restart from idle at positive half, Re note (H=8)
    for (int i = 0; i < 3; i++) step(3'b000, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step(3'b000, 1'b1, 1'b0);
    step(3'b010, 1'b0, 1'b0);
    chk(sl == 0, "R7 first edge still silent", int'(sl), 0);
    pos = 0;
    for (int i = 0; i < H[1]; i++) begin
      step(3'b010, 1'b0, 1'b0);
      if (sl == 16'sd8192) pos++;
    end
    chk(pos == H[1], "R7 R5 positive half length", pos, H[1]);
    step(3'b010, 1'b0, 1'b0);
    chk(sl == -16'sd8192, "R5 R8 negative half", int'(sl), -8192);

    // R6 release gives silence two edges later
    step(3'b000, 1'b0, 1'b0);
    step(3'b000, 1'b0, 1'b0);
    chk(sl == 0 && sr == 0, "R6 release silent", int'(sl), 0);

    // R1 reset mid-run
    for (int i = 0; i < 5; i++) step(3'b100, 1'b0, 1'b0);
    rst = 1'b1;
    step(3'b100, 1'b1, 1'b0);
    chk(lvl == 4'd8, "R1 mid-run level", int'(lvl), 8);
    chk(sl == 0, "R1 mid-run sample", int'(sl), 0);
    rst = 1'b0;
    for (int i = 0; i < 10; i++) step(3'b100, 1'b0, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule